// File: doc/BRIEF.md
# Scatter-Gather DMA Write Engine

This block moves a stream of 256-bit words, arriving from user logic, into a list of destination buffers in host or peer-device memory. Software fills up to a parameterised number of descriptors, each a 64-bit bus address and a byte length, then sets a run going with a start command. From then on the engine walks the list on its own. It cuts each buffer into write bursts that respect a selectable payload cap and never straddle a 4 KB page. It emits them as simplified memory-write beats on a request port.

Once the last data beat of the run has been taken by the request port, the engine writes one notification beat to a software-chosen address carrying the total byte count. It then holds until software writes a stop command as acknowledgement. A cycle counter measures the whole start-to-stop round trip and stays readable afterwards. A separate trigger register lets any bus master signal a pass or fail verdict on the delivered data.

Both streaming edges use valid/ready. On the input side, `in_ready` drops only when the internal buffer is full, and a word moves on any edge where `in_valid` and `in_ready` are both high. On the request side, once `req_valid` is high, the beat's address, length, flags and data stay fixed until an edge where `req_ready` is also high. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `sg_dma_writer`

## Requirements
- R1: After reset the status register (offset 0x004) reads 0, the latency register (offset 0x018) reads 0, `req_valid` is low and `in_ready` is high.
- R2: A register write to offset 0x000 with bit 0 set while idle starts a run: from the following cycle, status bit 0 (busy) reads 1.
- R3: A start write while busy is ignored: the latency count is not cleared, and the run delivers the same bursts, data and notification as it would have without it.
- R4: Descriptors (offset 0x100 + 16*index: +0x0 low address word, +0x4 high address word, +0x8 byte length, a multiple of 32) are served in index order from 0 up to the count written at offset 0x00C. Each is written to contiguous ascending addresses from its base, and a zero-length descriptor produces no beat.
- R5: Every data burst carries between 32 bytes and the cap selected by bit 0 of offset 0x008 (0: 128 bytes, 1: 256 bytes), and is as long as the cap, the remaining length and the distance to the next 4 KB boundary allow.
- R6: No data burst crosses a 4 KB address boundary.
- R7: The first beat of a burst is offered only when the buffer already holds every word of that burst.
- R8: Data words leave in the order they entered, one 32-byte word per beat. `req_bytes` and `req_addr` give the burst length and base on every beat, and `req_last` marks the final beat.
- R9: After the last data beat is accepted, a single beat with `req_notify` high goes to the address at offsets 0x010 (low) and 0x014 (high), with `req_bytes` 8, `req_last` high and the run's total byte count in data bits 63:0. A run with a count of 0 sends only this beat, carrying 0.
- R10: After the notification is accepted, status reads 3 (busy and awaiting acknowledge). A write to offset 0x000 with bit 1 set then returns the engine to idle, and the same command before that point is ignored.
- R11: The latency register is cleared on an accepted start, then counts every clock edge after the start edge and before the stop edge, and then holds its value.
- R12: `in_ready` is low when the buffer holds its full depth. A request beat stays unchanged while `req_valid` is high and `req_ready` is low.
- R13: A write to offset 0x01C raises `eval_pass` (bit 0) and/or `eval_fail` (bit 1) for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Buffer can accept a word |
| in_data | input | DATA_W | Input data word |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 9 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 9 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Request beat valid |
| req_ready | input | 1 | Request port accepts the beat |
| req_notify | output | 1 | Beat is the completion notification |
| req_addr | output | 64 | Burst or notification bus address |
| req_bytes | output | 16 | Burst or notification length in bytes |
| req_last | output | 1 | Final beat of the burst |
| req_data | output | DATA_W | Beat payload |
| eval_pass | output | 1 | One-cycle pass trigger |
| eval_fail | output | 1 | One-cycle fail trigger |

## Verification
The bench builds the engine with four descriptor slots and a 16-word buffer. With these values the whole list and a full-buffer state are each only a few writes away. Both payload caps are swept against descriptor bases stepped 32 bytes at a time across a 4 KB boundary, so every cut between cap, remainder and page limit is reached. Random stalls on both streams show the fill threshold and the holding of a stalled beat. Zero-length entries, an empty list, a repeated start and an early stop cover the remaining control corners.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PLAN,
    ST_FILL,
    ST_SEND,
    ST_NOTE,
    ST_ACK
  } seq_state_t;

  localparam logic [8:0] OFS_CTRL  = 9'h000;
  localparam logic [8:0] OFS_STAT  = 9'h004;
  localparam logic [8:0] OFS_CAP   = 9'h008;
  localparam logic [8:0] OFS_COUNT = 9'h00C;
  localparam logic [8:0] OFS_NLO   = 9'h010;
  localparam logic [8:0] OFS_NHI   = 9'h014;
  localparam logic [8:0] OFS_LAT   = 9'h018;
  localparam logic [8:0] OFS_TRIG  = 9'h01C;

  localparam logic [15:0] NOTE_BYTES = 16'd8;

endpackage

// File: rtl/sgdma_fifo.sv
module sgdma_fifo #(
  parameter int W     = 256,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push;

  assign push_ready = cnt < CW'(DEPTH);
  assign push       = push_valid && push_ready;
  assign head       = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int MAX_DESC = 16,
  parameter int CNT_W    = $clog2(MAX_DESC + 1),
  parameter int IDX_W    = $clog2(MAX_DESC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [8:0]       waddr,
  input  logic [31:0]      wdata,
  input  logic [8:0]       raddr,
  output logic [31:0]      rdata,
  input  logic             busy,
  input  logic             waiting,
  input  logic [31:0]      lat,
  output logic             start_cmd,
  output logic             stop_cmd,
  output logic             cap256,
  output logic [CNT_W-1:0] desc_cnt,
  output logic [63:0]      notify_addr,
  input  logic [IDX_W-1:0] desc_idx,
  output logic [63:0]      desc_addr,
  output logic [31:0]      desc_len,
  output logic             eval_pass,
  output logic             eval_fail
);
  logic [31:0] lo_q  [MAX_DESC];
  logic [31:0] hi_q  [MAX_DESC];
  logic [31:0] len_q [MAX_DESC];
  logic [3:0]  rslot;

  assign start_cmd = wr && (waddr == OFS_CTRL) && wdata[0];
  assign stop_cmd  = wr && (waddr == OFS_CTRL) && wdata[1];
  assign desc_addr = {hi_q[desc_idx], lo_q[desc_idx]};
  assign desc_len  = len_q[desc_idx];
  assign rslot     = raddr[7:4];

  for (genvar g = 0; g < MAX_DESC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q[g]  <= '0;
        hi_q[g]  <= '0;
        len_q[g] <= '0;
      end else if (wr && waddr[8] && (waddr[7:4] == 4'(g))) begin
        case (waddr[3:2])
          2'd0:    lo_q[g]  <= wdata;
          2'd1:    hi_q[g]  <= wdata;
          2'd2:    len_q[g] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap256      <= 1'b0;
      desc_cnt    <= '0;
      notify_addr <= '0;
      eval_pass   <= 1'b0;
      eval_fail   <= 1'b0;
    end else begin
      eval_pass <= wr && (waddr == OFS_TRIG) && wdata[0];
      eval_fail <= wr && (waddr == OFS_TRIG) && wdata[1];
      if (wr) begin
        case (waddr)
          OFS_CAP:   cap256 <= wdata[0];
          OFS_COUNT: desc_cnt <= (wdata > 32'(MAX_DESC)) ? CNT_W'(MAX_DESC)
                                                         : wdata[CNT_W-1:0];
          OFS_NLO:   notify_addr[31:0]  <= wdata;
          OFS_NHI:   notify_addr[63:32] <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr[8]) begin
      if (32'(rslot) < MAX_DESC) begin
        case (raddr[3:2])
          2'd0:    rdata = lo_q[rslot[IDX_W-1:0]];
          2'd1:    rdata = hi_q[rslot[IDX_W-1:0]];
          2'd2:    rdata = len_q[rslot[IDX_W-1:0]];
          default: rdata = '0;
        endcase
      end
    end else begin
      case (raddr)
        OFS_STAT:  rdata = {30'd0, waiting, busy};
        OFS_CAP:   rdata = {31'd0, cap256};
        OFS_COUNT: rdata = 32'(desc_cnt);
        OFS_NLO:   rdata = notify_addr[31:0];
        OFS_NHI:   rdata = notify_addr[63:32];
        OFS_LAT:   rdata = lat;
        default:   rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_seq.sv
module sgdma_seq
  import sgdma_pkg::*;
#(
  parameter int DATA_W = 256,
  parameter int CNT_W  = 5,
  parameter int IDX_W  = 4,
  parameter int FCW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              stop_acc,
  input  logic              cap256,
  input  logic [CNT_W-1:0]  desc_cnt,
  input  logic [63:0]       notify_addr,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic [63:0]       desc_addr,
  input  logic [31:0]       desc_len,
  input  logic [FCW-1:0]    fifo_cnt,
  input  logic [DATA_W-1:0] fifo_head,
  output logic              pop,
  output logic              busy,
  output logic              waiting,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_notify,
  output logic [63:0]       req_addr,
  output logic [15:0]       req_bytes,
  output logic              req_last,
  output logic [DATA_W-1:0] req_data
);
  localparam int SH = $clog2(DATA_W / 8);

  seq_state_t       state;
  logic [CNT_W-1:0] idx;
  logic [63:0]      cur_addr;
  logic [31:0]      remain;
  logic [15:0]      burst;
  logic [15:0]      beat;
  logic [63:0]      total;
  logic [15:0]      words;
  logic [12:0]      to_page;
  logic [31:0]      plan;
  logic             acc;

  assign desc_idx = idx[IDX_W-1:0];
  assign words    = burst >> SH;
  assign acc      = req_valid && req_ready;
  assign busy     = state != ST_IDLE;
  assign waiting  = state == ST_ACK;
  assign pop      = (state == ST_SEND) && acc;

  // Burst length: the smallest of cap, remainder and distance to the page end
  always_comb begin
    to_page = 13'h1000 - {1'b0, cur_addr[11:0]};
    plan    = remain;
    if ((cap256 ? 32'd256 : 32'd128) < plan) plan = cap256 ? 32'd256 : 32'd128;
    if (32'(to_page) < plan) plan = 32'(to_page);
  end

  always_comb begin
    req_valid  = (state == ST_SEND) || (state == ST_NOTE);
    req_notify = state == ST_NOTE;
    req_addr   = req_notify ? notify_addr : cur_addr;
    req_bytes  = req_notify ? NOTE_BYTES : burst;
    req_last   = req_notify || (beat == words - 16'd1);
    req_data   = req_notify ? {{(DATA_W - 64){1'b0}}, total} : fifo_head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      cur_addr <= '0;
      remain   <= '0;
      burst    <= '0;
      beat     <= '0;
      total    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_acc) begin
          idx   <= '0;
          total <= '0;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (idx == desc_cnt) begin
            state <= ST_NOTE;
          end else begin
            cur_addr <= {desc_addr[63:SH], {SH{1'b0}}};
            remain   <= {desc_len[31:SH], {SH{1'b0}}};
            state    <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (remain == '0) begin
            idx   <= idx + 1'b1;
            state <= ST_LOAD;
          end else begin
            burst <= plan[15:0];
            state <= ST_FILL;
          end
        end
        ST_FILL: if (16'(fifo_cnt) >= words) begin
          beat  <= '0;
          state <= ST_SEND;
        end
        ST_SEND: if (acc) begin
          if (beat == words - 16'd1) begin
            cur_addr <= cur_addr + 64'(burst);
            remain   <= remain - 32'(burst);
            total    <= total + 64'(burst);
            state    <= ST_PLAN;
          end else begin
            beat <= beat + 16'd1;
          end
        end
        ST_NOTE: if (acc) state <= ST_ACK;
        ST_ACK:  if (stop_acc) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgdma_lat.sv
module sgdma_lat #(
  parameter int LAT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_acc,
  input  logic             stop_acc,
  input  logic             busy,
  output logic [LAT_W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 lat <= '0;
    else if (start_acc)         lat <= '0;
    else if (busy && !stop_acc) lat <= lat + 1'b1;
  end
endmodule

// File: rtl/sg_dma_writer.sv
module sg_dma_writer #(
  parameter int DATA_W     = 256,
  parameter int MAX_DESC   = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              reg_wr,
  input  logic [8:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [8:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_notify,
  output logic [63:0]       req_addr,
  output logic [15:0]       req_bytes,
  output logic              req_last,
  output logic [DATA_W-1:0] req_data,
  output logic              eval_pass,
  output logic              eval_fail
);
  localparam int CNT_W = $clog2(MAX_DESC + 1);
  localparam int IDX_W = (MAX_DESC > 1) ? $clog2(MAX_DESC) : 1;
  localparam int FCW   = $clog2(FIFO_DEPTH + 1);

  logic              start_cmd, stop_cmd, start_acc, stop_acc;
  logic              busy, waiting, cap256, pop;
  logic [CNT_W-1:0]  desc_cnt;
  logic [IDX_W-1:0]  desc_idx;
  logic [63:0]       notify_addr, desc_addr;
  logic [31:0]       desc_len, lat_val;
  logic [FCW-1:0]    fifo_cnt;
  logic [DATA_W-1:0] fifo_head;

  assign start_acc = start_cmd && !busy;
  assign stop_acc  = stop_cmd && waiting;

  sgdma_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .CW(FCW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_valid(in_valid), .push_ready(in_ready),
    .push_data(in_data), .pop(pop), .head(fifo_head), .cnt(fifo_cnt)
  );

  sgdma_regs #(.MAX_DESC(MAX_DESC), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .busy(busy), .waiting(waiting),
    .lat(lat_val), .start_cmd(start_cmd), .stop_cmd(stop_cmd), .cap256(cap256),
    .desc_cnt(desc_cnt), .notify_addr(notify_addr), .desc_idx(desc_idx),
    .desc_addr(desc_addr), .desc_len(desc_len), .eval_pass(eval_pass),
    .eval_fail(eval_fail)
  );

  sgdma_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .FCW(FCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .stop_acc(stop_acc),
    .cap256(cap256), .desc_cnt(desc_cnt), .notify_addr(notify_addr),
    .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_len(desc_len),
    .fifo_cnt(fifo_cnt), .fifo_head(fifo_head), .pop(pop), .busy(busy),
    .waiting(waiting), .req_valid(req_valid), .req_ready(req_ready),
    .req_notify(req_notify), .req_addr(req_addr), .req_bytes(req_bytes),
    .req_last(req_last), .req_data(req_data)
  );

  sgdma_lat #(.LAT_W(32)) u_lat (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .stop_acc(stop_acc),
    .busy(busy), .lat(lat_val)
  );
endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_notify,
  input logic [63:0]       req_addr,
  input logic [15:0]       req_bytes,
  input logic              req_last,
  input logic [DATA_W-1:0] req_data,
  input logic              cap256,
  input logic              busy,
  input logic              waiting,
  input logic              start_acc,
  input logic [31:0]       lat_val
);
  // R5: burst length within the selected cap and never empty
  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_notify) |->
      (req_bytes != 16'd0) && (req_bytes <= (cap256 ? 16'd256 : 16'd128)));

  // R6: a data burst ends at or before the next 4 KB boundary
  p_no_page_cross_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_notify) |->
      ({5'd0, req_addr[11:0]} + {1'b0, req_bytes}) <= 17'h1000);

  // R12: a stalled beat is held unchanged
  p_hold_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_addr) && $stable(req_data) &&
       $stable(req_notify) && $stable(req_bytes) && $stable(req_last)));

  // R9: the notification is a single last beat inside a run
  p_note_in_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_notify) |-> (busy && req_last));

  // R10: waiting for acknowledge only follows an accepted notification
  p_ack_after_note_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waiting) |-> $past(req_valid && req_ready && req_notify));

  // R11: the counter holds while idle unless a start arrives
  p_lat_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_acc) |=> $stable(lat_val));
endmodule

bind sg_dma_writer sgdma_chk #(.DATA_W(DATA_W)) u_sgdma_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_notify(req_notify), .req_addr(req_addr), .req_bytes(req_bytes),
  .req_last(req_last), .req_data(req_data), .cap256(cap256), .busy(busy),
  .waiting(waiting), .start_acc(start_acc), .lat_val(lat_val)
);

// File: tb/test_sg_dma_writer.sv
module test_sg_dma_writer;
  localparam int DW = 256;
  localparam int ND = 4;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          reg_wr = 1'b0;
  logic [8:0]    reg_waddr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [8:0]    reg_raddr = '0;
  logic [31:0]   reg_rdata;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic          req_notify;
  logic [63:0]   req_addr;
  logic [15:0]   req_bytes;
  logic          req_last;
  logic [DW-1:0] req_data;
  logic          eval_pass, eval_fail;

  sg_dma_writer #(.DATA_W(DW), .MAX_DESC(ND), .FIFO_DEPTH(DEPTH)) i_sg_dma_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_notify(req_notify),
    .req_addr(req_addr), .req_bytes(req_bytes), .req_last(req_last),
    .req_data(req_data), .eval_pass(eval_pass), .eval_fail(eval_fail)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int cyc = 0, last_edge = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench state for streams and expected bursts
  int          pushed = 0, popped = 0, feed_target = 0;
  bit          slow = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [63:0] exp_a [64];
  int          exp_b [64];
  int          nexp = 0, bi = 0, beat = 0;
  logic [63:0] exp_total = '0, exp_note = '0;
  bit          note_seen = 1'b0;
  logic [63:0] d_base [ND];
  int          d_len [ND];

  function automatic logic [DW-1:0] wd(input int k);
    return {8{32'hC0DE_0000 ^ 32'(k)}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1 last_edge = cyc;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    reg_raddr = a; #1 d = reg_rdata;
  endtask

  // stream driver and request monitor
  always @(negedge clk) begin
    int occ;
    bit do_push;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n) begin
      occ = pushed - popped;
      in_valid = (pushed < feed_target) && (!slow || lfsr[1]);
      in_data = wd(pushed);
      do_push = in_valid && in_ready;
      req_ready = !slow || lfsr[4] || lfsr[7];
      if (req_valid && req_ready) begin
        if (req_notify) begin
          chk(req_addr == exp_note, "R9 notify address", req_addr, exp_note);
          chk(req_data[63:0] == exp_total, "R9 notify byte count", req_data[63:0], exp_total);
          chk(req_bytes == 16'd8 && req_last, "R9 notify length/last", req_bytes, 8);
          chk(bi == nexp, "R9 notify after last burst", bi, nexp);
          note_seen = 1'b1;
        end else if (bi >= nexp) begin
          chk(1'b0, "R4 unexpected data beat", req_addr, 0);
        end else begin
          chk(req_addr == exp_a[bi], "R4 R6 burst address", req_addr, exp_a[bi]);
          chk(32'(req_bytes) == exp_b[bi], "R5 burst length", req_bytes, exp_b[bi]);
          if (beat == 0)
            chk(occ >= exp_b[bi] / 32, "R7 buffered words at burst start", occ, exp_b[bi] / 32);
          chk(req_data == wd(popped), "R8 data order", req_data[31:0], wd(popped) & 32'hFFFF_FFFF);
          chk(req_last == (beat == exp_b[bi] / 32 - 1), "R8 last flag", req_last, beat);
          popped++;
          beat++;
          if (beat == exp_b[bi] / 32) begin beat = 0; bi++; end
        end
      end
      if (do_push) pushed++;
    end
  end

  task automatic run(input int n, input bit cap, input bit slw, input bit mid,
                     input logic [63:0] note);
    logic [31:0] v;
    int c0, cs, cap_b;
    logic [63:0] a;
    int l, b, t;
    cap_b = cap ? 256 : 128;
    nexp = 0; bi = 0; beat = 0; exp_total = '0; note_seen = 1'b0; exp_note = note;
    for (int i = 0; i < n; i++) begin
      a = d_base[i]; l = d_len[i];
      while (l > 0) begin
        t = 4096 - int'(a[11:0]);
        b = (l < cap_b) ? l : cap_b;
        if (t < b) b = t;
        exp_a[nexp] = a; exp_b[nexp] = b; nexp++;
        a = a + 64'(b); l = l - b; exp_total = exp_total + 64'(b);
      end
    end
    slow = slw;
    wr(9'h008, {31'd0, cap});
    wr(9'h00C, 32'(n));
    wr(9'h010, note[31:0]);
    wr(9'h014, note[63:32]);
    for (int i = 0; i < n; i++) begin
      wr(9'h100 + 9'(16 * i), d_base[i][31:0]);
      wr(9'h104 + 9'(16 * i), d_base[i][63:32]);
      wr(9'h108 + 9'(16 * i), 32'(d_len[i]));
    end
    feed_target = popped + int'(exp_total / 32);
    wr(9'h000, 32'h1);
    c0 = last_edge;
    rd(9'h018, v); chk(v == 0, "R11 latency cleared on start", v, 0);
    rd(9'h004, v); chk(v[0] == 1'b1, "R2 busy after start", v, 1);
    if (mid) begin
      wr(9'h000, 32'h1);
      rd(9'h018, v);
      chk(v == 32'(last_edge - c0), "R3 repeated start ignored", v, last_edge - c0);
      wr(9'h000, 32'h2);
      rd(9'h004, v); chk(v == 32'h1, "R10 early stop ignored", v, 1);
    end
    for (int i = 0; i < 6000 && !note_seen; i++) @(negedge clk);
    chk(note_seen, "R9 notification arrived", note_seen, 1);
    repeat (4) @(negedge clk);
    rd(9'h004, v); chk(v == 32'h3, "R10 awaiting acknowledge", v, 3);
    chk(bi == nexp && pushed == popped, "R4 all bursts delivered", bi, nexp);
    wr(9'h000, 32'h2);
    cs = last_edge;
    rd(9'h004, v); chk(v == 0, "R10 idle after stop", v, 0);
    rd(9'h018, v); chk(v == 32'(cs - c0 - 1), "R11 round-trip count", v, cs - c0 - 1);
    repeat (3) @(negedge clk);
    rd(9'h018, v); chk(v == 32'(cs - c0 - 1), "R11 count frozen", v, cs - c0 - 1);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(9'h004, v); chk(v == 0, "R1 status after reset", v, 0);
    rd(9'h018, v); chk(v == 0, "R1 latency after reset", v, 0);
    chk(!req_valid, "R1 no request after reset", req_valid, 0);
    chk(in_ready, "R1 input ready after reset", in_ready, 1);

    // R13 trigger pulses
    wr(9'h01C, 32'h1);
    chk(eval_pass && !eval_fail, "R13 pass pulse", {eval_pass, eval_fail}, 2);
    @(negedge clk);
    chk(!eval_pass && !eval_fail, "R13 pulse one cycle", {eval_pass, eval_fail}, 0);
    wr(9'h01C, 32'h2);
    chk(!eval_pass && eval_fail, "R13 fail pulse", {eval_pass, eval_fail}, 1);
    @(negedge clk);
    chk(!eval_fail, "R13 fail pulse one cycle", eval_fail, 0);

    // R5 R6 sweep: both caps, bases stepped across a page boundary
    for (int cp = 0; cp < 2; cp++) begin
      for (int off = 0; off < 8; off++) begin
        d_base[0] = 64'h0000_0001_0000_0F00 + 64'(off * 32);
        d_len[0]  = 'h140;
        d_base[1] = 64'h0000_0002_0000_2FC0 - 64'(off * 32);
        d_len[1]  = 'h80 + off * 32;
        run(2, cp[0], 1'b0, 1'b0, 64'h0000_00F0_0000_1000 + 64'(off * 8));
      end
    end

    // R12 full buffer while idle, then a stalled run using that data
    feed_target = popped + DEPTH;
    repeat (40) @(negedge clk);
    chk(!in_ready, "R12 input blocked when full", in_ready, 0);
    chk(pushed - popped == DEPTH, "R12 buffer holds its depth", pushed - popped, DEPTH);
    d_base[0] = 64'h0000_0003_0000_0FE0; d_len[0] = 'h80;
    d_base[1] = 64'h0000_0009_0000_0000; d_len[1] = 0;
    d_base[2] = 64'h0000_0004_0000_0100; d_len[2] = 'h200;
    d_base[3] = 64'h0000_0005_0000_2F40; d_len[3] = 'h100;
    run(4, 1'b1, 1'b1, 1'b1, 64'h0000_00F1_0000_0040);
    run(4, 1'b0, 1'b1, 1'b0, 64'h0000_00F1_0000_0080);

    // R9 empty list: notification only
    run(0, 1'b1, 1'b0, 1'b0, 64'h0000_00F2_0000_0000);

    finish_up();
  end
endmodule